// File: doc/BRIEF.md
# Supervisor reset and watchdog

This block produces the active-low system reset for a processor from three causes. The first is a supply-below-trip indication. The second is a programmable watchdog that software must service. The third is a manual reset switch, seen through the same open-drain reset pin that the block drives. All durations are counted in periods of an external time-base tick, nominally 100 ms, so a bench can scale them down. The analog trip detection and the pull-up stay outside the block. It sees only a digital low-supply flag and the sampled level of the pin, and it returns a pull-down enable for the pin.

Software sees two byte registers through a simple write strobe and a combinational readback. The watchdog control byte (select 0) holds the enable and the timeout code. The restart-and-cause byte (select 1) takes the restart key when written and reports two sticky cause bits when read. The watchdog runs freely whether or not it is enabled. It picks up a new timeout only when it restarts, and its all-ones code parks it.

Top module: `sup_rst_wdog`

## Requirements
- R1: After the block's own reset the pin is not driven, the control byte reads 1Fh (enable in bit 7 clear, timeout code in bits 4:0 all ones, other bits 0) and the cause byte reads 00h.
- R2: After a restart that loaded timeout code N (1 to 30), an enabled watchdog drives the pin on the N-th tick that follows, and code 0 acts like code 1.
- R3: Timeout code 11111b stops the watchdog counter, so no watchdog reset ever follows.
- R4: With the enable bit (bit 7 of the control byte) at 0 the counter still runs but never drives the pin.
- R5: A write to select 1 whose bits 3:0 equal 1010b clears the counter and loads the current timeout code, whatever bits 7:4 hold; a write to select 1 with any other low nibble leaves the counter untouched.
- R6: The counter compares against the code loaded at the last restart, not the live control byte.
- R7: A reset pulse is released on the PULSE_LEN-th tick after its trigger, or after the supply recovers; on release the watchdog restarts and loads the current code.
- R8: While the supply is below trip the pin is driven, ticks do not shorten the pulse, and the watchdog counter is held cleared.
- R9: A low pin level seen while the block is not driving starts a full reset pulse; a low level caused by the block's own pulse does not start another.
- R10: Cause bit 7 (watchdog) and bit 6 (supply-low or manual) of the cause byte are set by their events and can be set together; writing 0 to a bit clears it, writing 1 leaves it as it is, and bits 5:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the block's flops |
| tick_i | input | 1 | One-cycle time-base strobe, one per timeout unit |
| supply_low_i | input | 1 | High while the supply is below the trip point |
| pin_in_i | input | 1 | Sampled level of the reset pin (0 = low) |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control byte, 1 restart-and-cause byte |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Readback of the selected register |
| pin_drive_o | output | 1 | 1 pulls the reset pin low |

## Verification
The hardest situation to reach is both cause bits being set at once. It needs a low-supply episode first. Then, after the pulse is released, the automatic watchdog restart must run to a timeout before software clears anything. The stimulus gets there by arming the shortest timeout and holding the supply low across several ticks. It waits out the pulse and gives one more tick, so the restarted watchdog fires on its own. A second hard spot is a manual press during a pulse that is already running, which must not stretch it. The bench presses the switch one tick into a pulse and checks that the release tick does not move.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
   localparam int          REG_W       = 8;
   localparam logic [3:0]  RESTART_KEY = 4'b1010;
   localparam int          EN_BIT      = 7;
   localparam int          WTR_BIT     = 7;
   localparam int          POR_BIT     = 6;

   typedef enum logic {
      SEL_WDCTL = 1'b0,
      SEL_CAUSE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int TMO_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             hold_i,
   input  logic             restart_i,
   input  logic [TMO_W-1:0] tmo_i,
   output logic             expire_o
);
   logic [TMO_W-1:0] ld_q;
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   nxt;
   logic             parked;

   assign parked   = &ld_q;
   assign nxt      = {1'b0, cnt_q} + 1'b1;
   assign expire_o = tick_i & ~hold_i & ~restart_i & ~parked &
                     (nxt >= {1'b0, ld_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q  <= '1;
         cnt_q <= '0;
      end else if (restart_i) begin
         ld_q  <= tmo_i;
         cnt_q <= '0;
      end else if (hold_i) begin
         cnt_q <= '0;
      end else if (tick_i && !parked) begin
         cnt_q <= expire_o ? '0 : nxt[TMO_W-1:0];
      end
   end

   // R3: the all-ones code freezes the counter between restarts
   a_r3_parked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (parked && !restart_i && !hold_i) |=> $stable(cnt_q));

   // R8: a held counter is cleared on the next cycle
   a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse #(
   parameter int PULSE_LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic supply_low_i,
   input  logic wd_fire_i,
   input  logic pin_in_i,
   output logic drive_o,
   output logic release_o,
   output logic manual_o
);
   localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

   logic            drive_q;
   logic [PC_W-1:0] pcnt_q;

   assign drive_o   = drive_q;
   assign manual_o  = ~pin_in_i & ~drive_q & ~supply_low_i;
   assign release_o = drive_q & ~supply_low_i & tick_i & (pcnt_q == PC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         pcnt_q  <= '0;
      end else if (supply_low_i) begin
         drive_q <= 1'b1;
         pcnt_q  <= '0;
      end else if (drive_q) begin
         if (tick_i) begin
            if (pcnt_q == PC_LAST) begin
               drive_q <= 1'b0;
               pcnt_q  <= '0;
            end else begin
               pcnt_q <= pcnt_q + 1'b1;
            end
         end
      end else if (wd_fire_i || manual_o) begin
         drive_q <= 1'b1;
         pcnt_q  <= '0;
      end
   end

   // R8: low supply forces the pin low on the next cycle
   a_r8_low_drives: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low_i |=> drive_q);

   // R7: a pulse ends only on a tick with the supply good
   a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_q) |-> ($past(tick_i) && !$past(supply_low_i)));

   // R9: a detected manual press starts a pulse
   a_r9_manual_starts: assert property (@(posedge clk) disable iff (!rst_n)
      manual_o |=> drive_q);
endmodule

// File: rtl/cause_flags.sv
module cause_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wtr_i,
   input  logic set_por_i,
   input  logic wr_i,
   input  logic wdata_wtr_i,
   input  logic wdata_por_i,
   output logic wtr_o,
   output logic por_o
);
   logic wtr_q, por_q;

   assign wtr_o = wtr_q;
   assign por_o = por_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wtr_q <= 1'b0;
         por_q <= 1'b0;
      end else begin
         wtr_q <= set_wtr_i | (wtr_q & ~(wr_i & ~wdata_wtr_i));
         por_q <= set_por_i | (por_q & ~(wr_i & ~wdata_por_i));
      end
   end

   // R10: a cause bit falls only after a write of 0 to it
   a_r10_wtr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wtr_q) |-> $past(wr_i && !wdata_wtr_i));
   a_r10_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_q) |-> $past(wr_i && !wdata_por_i));
   // R10: a set event wins over a clearing write
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wtr_i || set_por_i) |=> (wtr_q || por_q));
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog #(
   parameter int TMO_W     = 5,
   parameter int PULSE_LEN = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_i,
   input  logic                          supply_low_i,
   input  logic                          pin_in_i,
   input  logic                          reg_we_i,
   input  logic                          reg_sel_i,
   input  logic [sup_rst_pkg::REG_W-1:0] reg_wdata_i,
   output logic [sup_rst_pkg::REG_W-1:0] reg_rdata_o,
   output logic                          pin_drive_o
);
   import sup_rst_pkg::*;

   generate
      if (TMO_W < 1 || TMO_W > EN_BIT) begin : g_bad_tmo
         $error("TMO_W must lie between 1 and the enable bit position");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least one tick");
      end
   endgenerate

   logic             ctl_en_q;
   logic [TMO_W-1:0] ctl_tmo_q;
   logic             key_hit, cause_wr;
   logic             wd_expire, wd_fire, wd_restart, wd_hold;
   logic             drive, rel, manual;
   logic             wtr, por;
   logic             unused_bit5;

   assign unused_bit5 = reg_wdata_i[5];
   assign cause_wr    = reg_we_i && (reg_sel_i == SEL_CAUSE);
   assign key_hit     = cause_wr && (reg_wdata_i[3:0] == RESTART_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en_q  <= 1'b0;
         ctl_tmo_q <= '1;
      end else if (reg_we_i && reg_sel_i == SEL_WDCTL) begin
         ctl_en_q  <= reg_wdata_i[EN_BIT];
         ctl_tmo_q <= reg_wdata_i[TMO_W-1:0];
      end
   end

   assign wd_restart = key_hit | rel;
   assign wd_hold    = drive | supply_low_i;
   assign wd_fire    = wd_expire & ctl_en_q;

   wdog_core #(.TMO_W(TMO_W)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .hold_i    (wd_hold),
      .restart_i (wd_restart),
      .tmo_i     (ctl_tmo_q),
      .expire_o  (wd_expire)
   );

   rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .supply_low_i (supply_low_i),
      .wd_fire_i    (wd_fire),
      .pin_in_i     (pin_in_i),
      .drive_o      (drive),
      .release_o    (rel),
      .manual_o     (manual)
   );

   cause_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_wtr_i   (wd_fire),
      .set_por_i   (supply_low_i | manual),
      .wr_i        (cause_wr),
      .wdata_wtr_i (reg_wdata_i[WTR_BIT]),
      .wdata_por_i (reg_wdata_i[POR_BIT]),
      .wtr_o       (wtr),
      .por_o       (por)
   );

   assign pin_drive_o = drive;

   always_comb begin
      reg_rdata_o = '0;
      if (reg_sel_i == SEL_WDCTL) begin
         reg_rdata_o[EN_BIT]      = ctl_en_q;
         reg_rdata_o[TMO_W-1:0]   = ctl_tmo_q;
      end else begin
         reg_rdata_o[WTR_BIT]     = wtr;
         reg_rdata_o[POR_BIT]     = por;
      end
   end

   // R2: an enabled expiry pulls the pin on the next cycle
   a_r2_fire_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_expire && ctl_en_q) |=> pin_drive_o);

   // R4: a disabled expiry alone never pulls the pin
   a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_expire && !ctl_en_q && !supply_low_i && pin_in_i && !pin_drive_o)
      |=> !pin_drive_o);
endmodule

// File: tb/test_sup_rst_wdog.sv
module test_sup_rst_wdog;
   localparam int PL = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       supply_low = 1'b0;
   logic       button = 1'b0;
   logic       we = 1'b0;
   logic       sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       pin_drive;
   logic       pin_in;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   assign pin_in = ~(pin_drive | button);

   sup_rst_wdog #(.TMO_W(5), .PULSE_LEN(PL)) i_sup_rst_wdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .supply_low_i (supply_low),
      .pin_in_i     (pin_in),
      .reg_we_i     (we),
      .reg_sel_i    (sel),
      .reg_wdata_i  (wdata),
      .reg_rdata_o  (rdata),
      .pin_drive_o  (pin_drive)
   );

   // code[11:7], enable[6], expected firing tick[5:0] (0 = never in 40 ticks)
   localparam logic [11:0] VECS [0:6] = '{
      {5'd1,  1'b1, 6'd1},
      {5'd0,  1'b1, 6'd1},
      {5'd4,  1'b1, 6'd4},
      {5'd9,  1'b1, 6'd9},
      {5'd30, 1'b1, 6'd30},
      {5'd6,  1'b0, 6'd0},
      {5'd31, 1'b1, 6'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic s, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic s, input logic [7:0] exp, input string req);
      @(negedge clk);
      sel = s;
      #1;
      chk(req, {24'd0, rdata}, {24'd0, exp});
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   task automatic wait_release(output int n);
      n = 0;
      for (int p = 1; p <= 10; p++) begin
         do_tick();
         if (!pin_drive) begin
            n = p;
            break;
         end
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      int seen;
      int rel;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 drive", {31'd0, pin_drive}, 32'd0);
      rd(1'b0, 8'h1F, "R1 ctl");
      rd(1'b1, 8'h00, "R1 cause");

      // table of timeout cases: R2, R3, R4
      for (int v = 0; v < 7; v++) begin
         logic [4:0] code;
         logic       en;
         int         fire;
         string      tag;
         code = VECS[v][11:7];
         en   = VECS[v][6];
         fire = int'(VECS[v][5:0]);
         tag  = (fire != 0) ? "R2" : (en ? "R3" : "R4");
         wr(1'b0, {en, 2'b00, code});
         wr(1'b1, 8'h0A);
         seen = 0;
         for (int t = 1; t <= 40; t++) begin
            do_tick();
            if (pin_drive) begin
               seen = t;
               break;
            end
         end
         chk(tag, seen, fire);
         if (fire != 0) begin
            rd(1'b1, 8'h80, "R10 wtr set");
            wait_release(rel);
            chk("R7 pulse length", rel, PL);
            wr(1'b1, 8'h00);
         end
      end

      // R5: other nibble does not restart
      wr(1'b0, 8'h84);
      wr(1'b1, 8'h0A);
      ticks(2);
      wr(1'b1, 8'h05);
      ticks(1);
      chk("R5 non-key ignored t3", {31'd0, pin_drive}, 32'd0);
      ticks(1);
      chk("R5 non-key ignored t4", {31'd0, pin_drive}, 32'd1);
      wait_release(rel);
      wr(1'b1, 8'h00);

      // R5: key with upper bits set restarts; R10 writing 1 does not set
      wr(1'b0, 8'h84);
      wr(1'b1, 8'h0A);
      ticks(3);
      wr(1'b1, 8'hFA);
      rd(1'b1, 8'h00, "R10 write one no set");
      ticks(3);
      chk("R5 key restart early", {31'd0, pin_drive}, 32'd0);
      ticks(1);
      chk("R5 key restart fires", {31'd0, pin_drive}, 32'd1);
      wait_release(rel);
      wr(1'b1, 8'h00);

      // R6: loaded value, not live register
      wr(1'b0, 8'h83);
      wr(1'b1, 8'h0A);
      wr(1'b0, 8'h8A);
      ticks(3);
      chk("R6 loaded timeout", {31'd0, pin_drive}, 32'd1);
      wait_release(rel);
      wr(1'b1, 8'h00);

      // R8: supply low, watchdog held
      wr(1'b0, 8'h81);
      wr(1'b1, 8'h0A);
      @(negedge clk);
      supply_low = 1'b1;
      @(negedge clk);
      chk("R8 low drives", {31'd0, pin_drive}, 32'd1);
      ticks(5);
      chk("R8 held through ticks", {31'd0, pin_drive}, 32'd1);
      rd(1'b1, 8'h40, "R8 no watchdog cause while low");
      @(negedge clk);
      supply_low = 1'b0;
      ticks(PL - 1);
      chk("R7 after recovery early", {31'd0, pin_drive}, 32'd1);
      ticks(1);
      chk("R7 after recovery release", {31'd0, pin_drive}, 32'd0);
      rd(1'b1, 8'h40, "R10 por only");
      ticks(1);
      chk("R7 restart on release", {31'd0, pin_drive}, 32'd1);
      rd(1'b1, 8'hC0, "R10 both causes");
      wait_release(rel);
      wr(1'b1, 8'h80);
      rd(1'b1, 8'h80, "R10 per-bit clear");
      wr(1'b1, 8'h00);
      rd(1'b1, 8'h00, "R10 cleared");

      // R9: manual press, no retrigger, press during pulse ignored
      wr(1'b0, 8'h9F);
      wr(1'b1, 8'h0A);
      @(negedge clk);
      button = 1'b1;
      @(negedge clk);
      button = 1'b0;
      chk("R9 manual starts", {31'd0, pin_drive}, 32'd1);
      rd(1'b1, 8'h40, "R9 por cause");
      ticks(1);
      @(negedge clk);
      button = 1'b1;
      @(negedge clk);
      button = 1'b0;
      ticks(PL - 2);
      chk("R9 press in pulse early", {31'd0, pin_drive}, 32'd1);
      ticks(1);
      chk("R9 press in pulse ignored", {31'd0, pin_drive}, 32'd0);
      ticks(6);
      chk("R9 no self retrigger", {31'd0, pin_drive}, 32'd0);

      finish_run();
   end
endmodule